// File: doc/BRIEF.md
# Four-Beat Burst Address Generator

This block supplies the address for each beat of a four-beat memory burst. A full start address is captured whenever either of two address-strobe inputs is high at a rising clock edge: one strobe is driven by the processor and one by the cache controller. On later edges, the two lowest address bits step through the burst each time the active-low advance input is low. The upper bits keep the captured value for the whole burst.

A static order input selects the order of the beats. With the input high, the low bits are the start bits XOR a running 2-bit beat count (interleaved order). With the input low, the low bits count up modulo 4 from the start bits (linear order). After the fourth beat the count wraps, and the address returns to the start address. A last-beat flag marks the fourth beat so that a memory controller can close the burst.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, addr_o is all zeros and last_o is 0.
- R2: If sel_proc_i or sel_ctrl_i is high at a rising edge, addr_o equals the addr_i of that edge from the next cycle on, and the beat count restarts at 0 (last_o low).
- R3: When order_i is 1 (interleaved), addr_o[1:0] at beat k is start[1:0] XOR k. For example, start 01 gives 01, 00, 11, 10.
- R4: When order_i is 0 (linear), addr_o[1:0] at beat k is (start[1:0] + k) mod 4. For example, start 01 gives 01, 10, 11, 00.
- R5: The beat count advances only on edges where adv_ni is 0. While adv_ni is 1 and no strobe is high, addr_o holds its value.
- R6: Advancing never changes addr_o[ADDR_W-1:2]. These bits keep the loaded start value.
- R7: last_o is 1 exactly when the beat count is 3, that is, on the fourth beat.
- R8: An advance from the fourth beat wraps the count to 0. addr_o returns to the start address and last_o falls.
- R9: A strobe at the same edge as an advance takes priority. The new address is loaded and the count goes to 0, with no step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Start address to capture |
| sel_proc_i | input | 1 | Processor address strobe, active high |
| sel_ctrl_i | input | 1 | Controller address strobe, active high |
| adv_ni | input | 1 | Advance to the next beat, active low |
| order_i | input | 1 | 1 = interleaved order, 0 = linear order |
| addr_o | output | ADDR_W | Address of the current beat |
| last_o | output | 1 | High on the fourth beat |

## Verification
The bench runs full bursts from every start value in both orders and carries each one through the wrap. A design that adds where it should XOR, or the reverse, fails on odd start values. A design that stops at the fourth beat instead of wrapping never shows the start address again. Start addresses with low bits 11 and upper bits all ones catch a carry that leaks out of the low bits into the upper address. Held-advance cycles, and a strobe that coincides with an advance, show up a counter that steps without permission or that lets a step win over a load.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt #(
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  output logic [BEAT_W-1:0] beat_o,
  output logic              last_o
);
  logic [BEAT_W-1:0] beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     beat_q <= '0;
    else if (load_i) beat_q <= '0;
    else if (step_i) beat_q <= beat_q + 1'b1;  // natural wrap
  end

  assign beat_o = beat_q;
  assign last_o = &beat_q;

  // R5
  step_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> beat_o == BEAT_W'($past(beat_o) + 1'b1));

  // R9
  load_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (beat_o == '0 && !last_o));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_addr_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  burst_order_e      order_i,
  output logic [BEAT_W-1:0] low_o
);
  always_comb begin
    unique case (order_i)
      ORD_INTERLEAVE: low_o = start_i ^ beat_i;
      default:        low_o = start_i + beat_i;
    endcase
  end

  // R8: beat zero maps to the start in either order
  always_comb begin
    if (beat_i == '0) begin
      beat0_start_chk: assert (low_o == start_i);
    end
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              sel_proc_i,
  input  logic              sel_ctrl_i,
  input  logic              adv_ni,
  input  logic              order_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic                    load;
  logic                    step;
  logic [UPPER_W-1:0]      upper_q;
  logic [BEAT_W-1:0]       start_q;
  logic [BEAT_W-1:0]       beat;
  logic [BEAT_W-1:0]       low;
  burst_order_e            order;

  assign load  = sel_proc_i | sel_ctrl_i;
  assign step  = ~adv_ni;
  assign order = burst_order_e'(order_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upper_q <= '0;
      start_q <= '0;
    end else if (load) begin
      upper_q <= addr_i[ADDR_W-1:BEAT_W];
      start_q <= addr_i[BEAT_W-1:0];
    end
  end

  burst_beat_cnt #(.BEAT_W(BEAT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .step_i (step),
    .beat_o (beat),
    .last_o (last_o)
  );

  burst_order_map #(.BEAT_W(BEAT_W)) u_map (
    .start_i (start_q),
    .beat_i  (beat),
    .order_i (order),
    .low_o   (low)
  );

  assign addr_o = {upper_q, low};

  // R2
  load_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> addr_o == $past(addr_i));

  // R5
  hold_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load && adv_ni) |=> (!$stable(order_i) || $stable(addr_o)));

  // R6
  upper_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W]));

  // R8
  wrap_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && step && !load) |=> !last_o);
endmodule

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 17;
  localparam int WD_LIMIT = 20000;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          sel_proc_i = 1'b0;
  logic          sel_ctrl_i = 1'b0;
  logic          adv_ni = 1'b1;
  logic          order_i = 1'b0;
  logic [AW-1:0] addr_o;
  logic          last_o;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit done    = 0;

  burst_addr_gen #(.ADDR_W(AW), .BEAT_W(2)) u_burst_addr_gen (
    .clk_i, .rst_ni, .addr_i, .sel_proc_i, .sel_ctrl_i,
    .adv_ni, .order_i, .addr_o, .last_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > WD_LIMIT && !done) begin
      errors++;
      $display("FAIL watchdog: act=%0d cycles exp<=%0d", cycles, WD_LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] s, int k, bit il);
    logic [1:0] kb;
    logic [1:0] lo;
    kb = 2'(k);
    lo = il ? (s[1:0] ^ kb) : 2'(s[1:0] + kb);
    return {s[AW-1:2], lo};
  endfunction

  task automatic load(logic [AW-1:0] a, bit use_ctrl, bit adv);
    addr_i = a; sel_proc_i = !use_ctrl; sel_ctrl_i = use_ctrl; adv_ni = !adv;
    tick();
    sel_proc_i = 0; sel_ctrl_i = 0; adv_ni = 1; addr_i = '1;
  endtask

  task automatic t_reset();
    chk("R1 addr", addr_o, '0);
    chk("R1 last", AW'(last_o), '0);
  endtask

  // R2 R3 R4 R6 R7 R8: full burst plus wrap
  task automatic t_burst(logic [AW-1:0] s, bit il, bit use_ctrl);
    string rq;
    rq = il ? "R3/R6 interleaved" : "R4/R6 linear";
    order_i = il;
    load(s, use_ctrl, 0);
    chk("R2 load", addr_o, s);
    chk("R2 last", AW'(last_o), '0);
    for (int k = 1; k <= 4; k++) begin
      adv_ni = 0;
      tick();
      adv_ni = 1;
      if (k == 4) chk("R8 wrap", addr_o, s);
      else        chk(rq, addr_o, exp_addr(s, k, il));
      chk("R7 last", AW'(last_o), AW'(k == 3));
    end
  endtask

  // R5: held advance keeps address
  task automatic t_hold();
    logic [AW-1:0] s;
    s = 17'h0A5A2;
    order_i = 0;
    load(s, 0, 0);
    adv_ni = 0; tick(); adv_ni = 1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R5 hold", addr_o, exp_addr(s, 1, 0));
    end
    adv_ni = 0; tick(); adv_ni = 1;
    chk("R5 resume", addr_o, exp_addr(s, 2, 0));
  endtask

  // R9: strobe with advance loads, does not step
  task automatic t_priority();
    logic [AW-1:0] a;
    logic [AW-1:0] b;
    a = 17'h12341; b = 17'h0F0F3;
    order_i = 1;
    load(a, 1, 0);
    adv_ni = 0; tick(); tick(); adv_ni = 1;
    load(b, 0, 1);
    chk("R9 load wins", addr_o, b);
    chk("R9 last", AW'(last_o), '0);
    adv_ni = 0; tick(); adv_ni = 1;
    chk("R9 step after", addr_o, exp_addr(b, 1, 1));
  endtask

  initial begin
    #(CLK_PERIOD*2 + 1);
    t_reset();
    rst_ni = 1;
    tick();
    t_reset();
    for (int st = 0; st < 4; st++) begin
      t_burst({15'h5A3C, 2'(st)}, 1, st[0]);
      t_burst({15'h1234, 2'(st)}, 0, !st[0]);
    end
    t_burst(17'h1FFFF, 0, 0);
    t_burst(17'h1FFFD, 1, 1);
    t_hold();
    t_priority();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule